// File: doc/BRIEF.md
# Accumulate-Mode Hash Padding Detector

This block watches a stream of hash requests that together make up one message. It keeps a running byte total across the requests and decides, for each one, whether that request is the last one. It does not rely on any end-of-list marker. The last request is the one that carries the message's final padding.

For every request the block is given three things: the request length, the request's final eight bytes, and a byte read port into the request buffer. The final eight bytes are read as a big-endian bit count. That count, divided by eight, gives a candidate message length. When the candidate is within the running total, the block works out where padding would start in the current request. It then reads that one byte through the read port. A value of 0x80 there confirms the padding.

On a confirmed hit the block reports three things: the trimmed usable length of the request, the message length, and how many data segments make up the message. It then forgets the running total and the segment count. On a miss the request is counted as one more cached segment. Computing the hash and fetching memory are left to the surrounding logic.

Top module: `padx_detect`

## Requirements
- R1: When a request is accepted (`req_valid` high while `req_ready` is high), its length is added to the running total before the padding check is made, so the check sees the sum of all request lengths since the last hit or clear.
- R2: The candidate message length is the 64-bit big-endian value of the request's final eight bytes (`req_tail[63:56]` is the first byte), shifted right by three and truncated to `LEN_W` bits. It is reported on `res_msg_len` for every result.
- R3: When the candidate exceeds the running total, the request is a miss and no byte lookup is issued (`rd_req` stays low).
- R4: Otherwise a lookup is issued at offset = request length − (running total − candidate). `rd_req` stays high, with `rd_off` held steady, until `rd_valid` answers.
- R5: Padding is confirmed only when the byte returned at that offset equals 0x80. Any other value makes the request a miss.
- R6: On a miss, `res_pad` is 0, `res_len` is the full untrimmed request length, the cached segment count goes up by one, and `res_segs` reports the new count. The running total is kept.
- R7: On a hit, `res_pad` is 1, `res_len` is the padding offset, and `res_segs` is computed as follows. It is 1 when no segments were cached. Otherwise it is the cached count, plus one only when the offset is non-zero. An offset of zero means there is no partial tail segment.
- R8: After a hit, the running total and the segment count are both zero, so the next request starts a new message.
- R9: Each accepted request produces exactly one result. The result is shown as a single-cycle `res_valid` pulse, and `req_ready` is low from acceptance until that pulse.
- R10: A synchronous `clr` zeroes the running total and the segment count and abandons any request in progress, producing no result for it.
- R11: After reset, `req_ready` is 1 and `res_valid` and `rd_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of accumulator, segment count and sequencer |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_len | input | LEN_W | Request length in bytes |
| req_tail | input | 64 | Final eight bytes of the request, first byte in bits 63:56 |
| rd_req | output | 1 | Byte lookup request |
| rd_off | output | LEN_W | Byte offset into the current request buffer |
| rd_valid | input | 1 | Lookup answer present |
| rd_data | input | 8 | Byte returned by the lookup |
| res_valid | output | 1 | Single-cycle result strobe |
| res_pad | output | 1 | Padding confirmed in this request |
| res_len | output | LEN_W | Usable length: padding offset on a hit, full length on a miss |
| res_msg_len | output | LEN_W | Candidate message length from the embedded bit count |
| res_segs | output | SEG_W | Segment count of the message on a hit, cached count on a miss |

## Verification
The embedded assertions check, on every cycle, the behaviour that can be seen locally. They cover the accumulator arithmetic at each acceptance, the clearing after a hit or `clr`, and the segment counting on a miss. They also cover the steady lookup handshake, the single-cycle result strobe, and `req_ready` staying low while a request is in flight.

Some behaviour can only be shown by the bench's scenarios, which compare the results against an independent model. This includes whether a request is a hit for a given mix of lengths and bit counts, and the big-endian reading of the tail. It also includes the trimmed offset and the segment count in the zero-offset and no-cache cases, and the absence of a lookup when the candidate is too large.

// File: rtl/padx_pkg.sv
package padx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_EVAL  = 2'd1,
      ST_PROBE = 2'd2
   } padx_state_e;

   localparam logic [7:0] PAD_MARK = 8'h80;
endpackage

// File: rtl/padx_accum.sv
module padx_accum #(
   parameter int LEN_W    = 32,
   parameter int SEG_W    = 8,
   parameter bit SEG_SAT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  logic [LEN_W-1:0] add_len,
   input  logic             hit,
   input  logic             miss,
   output logic [LEN_W-1:0] total,
   output logic [SEG_W-1:0] segs
);
   localparam logic [SEG_W-1:0] SEG_MAX = {SEG_W{1'b1}};

   logic [SEG_W-1:0] segs_inc;

   generate
      if (SEG_SAT) begin : g_sat
         assign segs_inc = (segs == SEG_MAX) ? SEG_MAX : segs + 1'b1;
      end else begin : g_wrap
         assign segs_inc = segs + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total <= '0;
         segs  <= '0;
      end else if (clr || hit) begin
         total <= '0;
         segs  <= '0;
      end else begin
         if (add_en) total <= total + add_len;
         if (miss)   segs  <= segs_inc;
      end
   end

   // R1
   sum_before_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (add_en && !clr && !hit) |=> (total == $past(total) + $past(add_len)));

   // R8
   hit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (total == '0 && segs == '0));

   // R10
   clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (total == '0 && segs == '0));

   // R6
   miss_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss && !clr && !hit) |=>
         (segs == ((SEG_SAT && $past(segs) == SEG_MAX) ? SEG_MAX : $past(segs) + 1'b1)));
endmodule

// File: rtl/padx_offset_calc.sv
module padx_offset_calc #(
   parameter int LEN_W = 32
) (
   input  logic [LEN_W-1:0] total,
   input  logic [LEN_W-1:0] cand,
   input  logic [LEN_W-1:0] len,
   output logic             eligible,
   output logic [LEN_W-1:0] pad_off
);
   logic [LEN_W-1:0] pad_size;

   always_comb begin
      eligible = (cand <= total);
      pad_size = total - cand;
      pad_off  = len - pad_size;
   end
endmodule

// File: rtl/padx_detect.sv
module padx_detect
   import padx_pkg::*;
#(
   parameter int LEN_W   = 32,
   parameter int SEG_W   = 8,
   parameter bit SEG_SAT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [LEN_W-1:0] req_len,
   input  logic [63:0]      req_tail,
   output logic             rd_req,
   output logic [LEN_W-1:0] rd_off,
   input  logic             rd_valid,
   input  logic [7:0]       rd_data,
   output logic             res_valid,
   output logic             res_pad,
   output logic [LEN_W-1:0] res_len,
   output logic [LEN_W-1:0] res_msg_len,
   output logic [SEG_W-1:0] res_segs
);
   localparam int CAND_LO = 3;
   localparam int CAND_HI = LEN_W + CAND_LO - 1;

   generate
      if (LEN_W < 8 || CAND_HI > 63) begin : g_bad_len
         $error("padx_detect: LEN_W must lie in 8..61");
      end
      if (SEG_W < 2) begin : g_bad_seg
         $error("padx_detect: SEG_W must be at least 2");
      end
   endgenerate

   padx_state_e      state_q;
   logic [LEN_W-1:0] len_q, cand_q, off_q;
   logic [LEN_W-1:0] total;
   logic [SEG_W-1:0] segs;
   logic             eligible;
   logic [LEN_W-1:0] pad_off;
   logic             accept, hit, miss, eval_miss, probe_done;
   logic [SEG_W-1:0] hit_segs;

   assign req_ready  = (state_q == ST_IDLE);
   assign accept     = req_valid && req_ready && !clr;
   assign probe_done = (state_q == ST_PROBE) && rd_valid && !clr;
   assign eval_miss  = (state_q == ST_EVAL) && !eligible && !clr;
   assign hit        = probe_done && (rd_data == PAD_MARK);
   assign miss       = eval_miss || (probe_done && (rd_data != PAD_MARK));
   assign rd_req     = (state_q == ST_PROBE);
   assign rd_off     = off_q;
   assign hit_segs   = (segs == '0) ? {{(SEG_W-1){1'b0}}, 1'b1}
                                    : segs + {{(SEG_W-1){1'b0}}, (off_q != '0)};

   padx_accum #(
      .LEN_W   (LEN_W),
      .SEG_W   (SEG_W),
      .SEG_SAT (SEG_SAT)
   ) i_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .add_en  (accept),
      .add_len (req_len),
      .hit     (hit),
      .miss    (miss),
      .total   (total),
      .segs    (segs)
   );

   padx_offset_calc #(
      .LEN_W (LEN_W)
   ) i_offset (
      .total    (total),
      .cand     (cand_q),
      .len      (len_q),
      .eligible (eligible),
      .pad_off  (pad_off)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         len_q       <= '0;
         cand_q      <= '0;
         off_q       <= '0;
         res_valid   <= 1'b0;
         res_pad     <= 1'b0;
         res_len     <= '0;
         res_msg_len <= '0;
         res_segs    <= '0;
      end else begin
         res_valid <= 1'b0;
         if (clr) begin
            state_q <= ST_IDLE;
         end else begin
            unique case (state_q)
               ST_IDLE: if (accept) begin
                  len_q   <= req_len;
                  cand_q  <= req_tail[CAND_HI:CAND_LO];
                  state_q <= ST_EVAL;
               end
               ST_EVAL: if (eligible) begin
                  off_q   <= pad_off;
                  state_q <= ST_PROBE;
               end else begin
                  res_valid   <= 1'b1;
                  res_pad     <= 1'b0;
                  res_len     <= len_q;
                  res_msg_len <= cand_q;
                  res_segs    <= (SEG_SAT && segs == {SEG_W{1'b1}}) ? segs : segs + 1'b1;
                  state_q     <= ST_IDLE;
               end
               ST_PROBE: if (rd_valid) begin
                  res_valid   <= 1'b1;
                  res_pad     <= hit;
                  res_len     <= hit ? off_q : len_q;
                  res_msg_len <= cand_q;
                  res_segs    <= hit ? hit_segs
                                     : ((SEG_SAT && segs == {SEG_W{1'b1}}) ? segs : segs + 1'b1);
                  state_q     <= ST_IDLE;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   // R9
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R9
   busy_until_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept) |=> !req_ready);

   // R4
   lookup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid && !clr) |=> (rd_req && $stable(rd_off)));

   // R3
   no_lookup_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eval_miss |=> !rd_req);

   // R7
   hit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (res_valid && res_pad && res_len == $past(rd_off)));
endmodule

// File: tb/test_padx_detect.sv
module test_padx_detect;
   localparam int LEN_W = 32;
   localparam int SEG_W = 8;

   typedef struct {
      logic             pad;
      logic [LEN_W-1:0] len;
      logic [LEN_W-1:0] msg;
      logic [SEG_W-1:0] segs;
      string            tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clr = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [LEN_W-1:0] req_len = '0;
   logic [63:0]      req_tail = '0;
   logic             rd_req;
   logic [LEN_W-1:0] rd_off;
   logic             rd_valid = 1'b0;
   logic [7:0]       rd_data = '0;
   logic             res_valid, res_pad;
   logic [LEN_W-1:0] res_len, res_msg_len;
   logic [SEG_W-1:0] res_segs;

   exp_t             q[$];
   int               checks = 0;
   int               fails = 0;
   int               cycles = 0;
   logic [LEN_W-1:0] m_total = '0;
   int               m_cache = 0;
   int               exp_lookups = 0;
   int               seen_lookups = 0;
   int               results = 0;
   logic [LEN_W-1:0] mark_off = '0;
   logic [7:0]       mark_val = '0;
   logic             rd_req_d = 1'b0;

   always #2.5 clk = ~clk;

   padx_detect #(.LEN_W(LEN_W), .SEG_W(SEG_W)) i_padx_detect (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_len(req_len), .req_tail(req_tail),
      .rd_req(rd_req), .rd_off(rd_off), .rd_valid(rd_valid), .rd_data(rd_data),
      .res_valid(res_valid), .res_pad(res_pad), .res_len(res_len),
      .res_msg_len(res_msg_len), .res_segs(res_segs)
   );

   // buffer model: answers one lookup per request, one cycle later
   always @(negedge clk) begin
      if (rd_valid) rd_valid = 1'b0;
      else if (rd_req) begin
         rd_valid = 1'b1;
         rd_data  = (rd_off == mark_off) ? mark_val : 8'h00;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      rd_req_d <= rd_req;
      if (rd_req && !rd_req_d) seen_lookups <= seen_lookups + 1;
   end

   task automatic check(input bit ok, input string msg);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s", msg);
      end
   endtask

   // monitor: pops the scoreboard at every result strobe
   always @(posedge clk) begin
      #1;
      if (res_valid) begin
         results++;
         if (q.size() == 0) begin
            check(1'b0, $sformatf("R9 unexpected result: actual pad=%0d len=%0d expected none",
                                  res_pad, res_len));
         end else begin
            exp_t e;
            e = q.pop_front();
            check(res_pad == e.pad && res_len == e.len && res_msg_len == e.msg && res_segs == e.segs,
                  $sformatf("%s actual pad=%0d len=%0d msg=%0d segs=%0d expected pad=%0d len=%0d msg=%0d segs=%0d",
                            e.tag, res_pad, res_len, res_msg_len, res_segs,
                            e.pad, e.len, e.msg, e.segs));
         end
      end
   end

   // driver: model the expected outcome (R1 R2 R3 R4 R5 R6 R7 R8) and push it
   task automatic send(input logic [LEN_W-1:0] len, input logic [63:0] tail,
                       input logic [LEN_W-1:0] moff, input logic [7:0] mval,
                       input string tag);
      exp_t e;
      logic [LEN_W-1:0] cand, off;
      int n;
      while (!req_ready) @(negedge clk);
      mark_off = moff;
      mark_val = mval;
      m_total = m_total + len;
      cand = LEN_W'(tail >> 3);
      e.msg = cand;
      e.tag = tag;
      if (cand <= m_total) begin
         exp_lookups++;
         off = len - (m_total - cand);
         if (off == moff && mval == 8'h80) begin
            e.pad = 1'b1;
            e.len = off;
            e.segs = (m_cache == 0) ? SEG_W'(1) : SEG_W'(m_cache + ((off != 0) ? 1 : 0));
            m_total = '0;
            m_cache = 0;
         end else begin
            m_cache++;
            e.pad = 1'b0; e.len = len; e.segs = SEG_W'(m_cache);
         end
      end else begin
         m_cache++;
         e.pad = 1'b0; e.len = len; e.segs = SEG_W'(m_cache);
      end
      q.push_back(e);
      n = results;
      req_len = len; req_tail = tail; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (results == n) @(negedge clk);
      @(negedge clk);
   endtask

   localparam logic [63:0] BIG = 64'hFFFF_FFFF_FFFF_FFF8;

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check(req_ready == 1'b1, $sformatf("R11 req_ready actual %0d expected 1", req_ready));
      check(res_valid == 1'b0, $sformatf("R11 res_valid actual %0d expected 0", res_valid));
      check(rd_req == 1'b0, $sformatf("R11 rd_req actual %0d expected 0", rd_req));
      rst_n = 1'b1;
      @(negedge clk);

      // single request carrying its own padding (R2 R4 R7)
      send(64, 64'd55 * 8, 55, 8'h80, "R7 single hit");
      // two cached requests then a final one (R1 R3 R6 R7 R8)
      send(64, BIG, 0, 8'h00, "R3 miss no lookup");
      send(64, BIG, 0, 8'h00, "R6 second cached");
      send(64, 64'd150 * 8, 22, 8'h80, "R1 three-part message");
      // eligible but wrong marker, then hit (R5)
      send(32, 64'd20 * 8, 20, 8'h00, "R5 zero marker rejected");
      send(16, 64'd40 * 8, 8, 8'h80, "R5 hit after rejected");
      send(32, 64'd32 * 8, 32, 8'h81, "R5 0x81 rejected");
      send(8, 64'd40 * 8, 8, 8'h80, "R8 fresh after hit");
      // zero offset: no partial tail segment (R7)
      send(64, BIG, 0, 8'h00, "R6 cached before zero offset");
      send(8, 64'd64 * 8, 0, 8'h80, "R7 zero offset");
      // candidate equals total exactly (R4)
      send(40, 64'd40 * 8, 40, 8'h80, "R4 no padding bytes");
      // big-endian reading: byte order matters (R2)
      send(16, 64'h0000_0000_0000_0080, 16, 8'h80, "R2 big-endian tail");
      // synchronous clear between requests (R10)
      send(64, BIG, 0, 8'h00, "R10 cached before clear");
      clr = 1'b1; @(negedge clk); clr = 1'b0;
      m_total = '0; m_cache = 0;
      send(16, 64'd16 * 8, 16, 8'h80, "R10 fresh after clear");
      // clear while a request is in flight: no result (R10 R9)
      begin
         int n;
         n = results;
         req_len = 24; req_tail = 64'd24 * 8; req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0; clr = 1'b1;
         @(negedge clk);
         clr = 1'b0;
         repeat (4) @(negedge clk);
         check(results == n, $sformatf("R10 abort result count actual %0d expected %0d", results, n));
         check(req_ready == 1'b1, $sformatf("R10 ready after abort actual %0d expected 1", req_ready));
      end
      send(24, 64'd24 * 8, 24, 8'h80, "R10 clean after abort");
      // lookup only for eligible candidates (R3)
      check(seen_lookups == exp_lookups,
            $sformatf("R3 lookup count actual %0d expected %0d", seen_lookups, exp_lookups));
      check(q.size() == 0, $sformatf("R9 pending results actual %0d expected 0", q.size()));
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired: actual %0d cycles expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule